// File: doc/BRIEF.md
# Timer Channel: Capture, Compare and PWM

This block is one channel of a multi-channel timer. The timer owns a shared counter and feeds every channel its current value, its count direction, a counter-advance tick and a terminal-count strobe. The channel turns that time base into one of four behaviours: it can timestamp edges on an input pin, act on an output pin when the counter reaches a programmed value, produce an edge-aligned PWM waveform, or produce a center-aligned PWM waveform when the timer runs its counter up and down.

One value register serves every mode. In capture mode it receives counter snapshots. In compare mode it holds the match point. In PWM mode it is the front half of a double buffer for the duty value, so new duty values take effect only at a period boundary. One sticky event flag records captures and matches, and it can be gated onto an interrupt request line.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted and after reset, `ch_out`, `flag`, `irq` and `val_rd` are all 0.
- R2: `cap_in` passes through a two-flop synchronizer and then an edge detector. A pin change driven between clock edges k-1 and k becomes a capture event at edge k+2. At that event `val_rd` takes the `cnt_val` present just before that edge, and `flag` is set.
- R3: In capture mode (`mode`=0), `edge_sel` bit 0 enables capture on rising edges and bit 1 enables capture on falling edges. Value 3 captures on either edge, and value 0 never captures.
- R4: A pulse on `val_wr` loads `val_wdata` into the value register at the next edge in any mode, and `val_rd` shows it. A capture event in the same cycle takes priority over the write.
- R5: In compare mode (`mode`=1), a match is a cycle with `cnt_tick`=1 and `cnt_val` equal to the value register. At the edge that ends such a cycle, `ch_out` toggles (`edge_sel`=1), goes to 0 (`edge_sel`=2), goes to 1 (`edge_sel`=3) or holds (`edge_sel`=0). Without a match, `ch_out` holds.
- R6: In PWM mode (`mode`=2), `ch_out` is registered. At each edge it becomes the active level when `cnt_val` is below the active duty value, and the inactive level otherwise. `pol`=1 makes the active level high, and `pol`=0 makes it low.
- R7: In PWM mode the active duty value is copied from the value register only at an edge where `cnt_tick` and `tc_strobe` are both 1, and additionally `cnt_down`=0 when `center_en`=1. In any other mode, the active duty value follows the value register every cycle.
- R8: With `center_en`=1 and an up/down counter, the same rule gives a pulse centred on the count bottom. The output changes once on the upward match and once on the downward match.
- R9: `flag` is set by a capture event, a compare match, or a PWM match (`cnt_tick`=1 and `cnt_val` equal to the active duty). It stays set until a `flag_clr` pulse. A set in the same cycle wins over the clear.
- R10: `irq` is high exactly when `flag` and `irq_en` are both 1.
- R11: In idle mode (`mode`=3), `ch_out` is driven to 0 and `flag` is never set, while register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CW | Shared counter value |
| cnt_down | input | 1 | Counter is counting down (center mode) |
| cnt_tick | input | 1 | Counter advances at the coming edge |
| tc_strobe | input | 1 | Counter is at a terminal or turnaround value |
| center_en | input | 1 | Timer runs center-aligned up/down counting |
| mode | input | 2 | 0 capture, 1 compare, 2 PWM, 3 idle |
| edge_sel | input | 2 | Capture edge enables or compare action |
| pol | input | 1 | PWM active level, 1 = high |
| val_wr | input | 1 | Write strobe for the value register |
| val_wdata | input | CW | Write data |
| flag_clr | input | 1 | Clears the event flag |
| irq_en | input | 1 | Interrupt enable |
| cap_in | input | 1 | Asynchronous capture pin |
| ch_out | output | 1 | Channel output pin |
| val_rd | output | CW | Value register contents |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the three-edge capture latency and checks that the counter value latched is the one from the detection cycle; an off-by-one in the synchronizer would latch a neighbouring count. It changes the duty in mid-period and drops the tick on prescaled runs, so a design that loads duty immediately would glitch a pulse, and one that matches without the tick would act several times on one count. It also covers duty 0 and duty above the modulus, the boundaries of the comparison, and the center-mode load point: a design that reloads at the bottom turnaround would shift its pulses by half a period.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
   typedef enum logic [1:0] {
      CH_CAPTURE = 2'd0,
      CH_COMPARE = 2'd1,
      CH_PWM     = 2'd2,
      CH_IDLE    = 2'd3
   } ch_mode_e;

   typedef enum logic [1:0] {
      OC_NONE   = 2'd0,
      OC_TOGGLE = 2'd1,
      OC_CLEAR  = 2'd2,
      OC_SET    = 2'd3
   } oc_act_e;
endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_LEVEL  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sel,
   output logic       hit
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("tmr_chan_edge: SYNC_STAGES must be at least 2");
      end
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= IDLE_LEVEL;
               else        sync_q[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[g] <= IDLE_LEVEL;
               else        sync_q[g] <= sync_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= sync_q[LAST];

   assign rise = sync_q[LAST] & ~prev_q;
   assign fall = ~sync_q[LAST] & prev_q;
   assign hit  = (rise & sel[0]) | (fall & sel[1]);

   // R3: a detected edge always leaves the comparison stage changed one cycle on
   assert_edge_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (prev_q == $past(sync_q[LAST])));
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
   import tmr_chan_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ch_mode_e      mode,
   input  oc_act_e       act,
   input  logic          pol,
   input  logic [CW-1:0] cnt_val,
   input  logic          cnt_tick,
   input  logic [CW-1:0] cmp_val,
   input  logic [CW-1:0] duty,
   output logic          pin_out,
   output logic          hit_evt
);
   logic cmp_hit, pwm_hit, below, out_q, out_d;

   assign cmp_hit = (mode == CH_COMPARE) && cnt_tick && (cnt_val == cmp_val);
   assign pwm_hit = (mode == CH_PWM) && cnt_tick && (cnt_val == duty);
   assign below   = cnt_val < duty;
   assign hit_evt = cmp_hit | pwm_hit;

   always_comb begin
      out_d = out_q;
      unique case (mode)
         CH_COMPARE: begin
            if (cmp_hit) begin
               unique case (act)
                  OC_TOGGLE: out_d = ~out_q;
                  OC_CLEAR:  out_d = 1'b0;
                  OC_SET:    out_d = 1'b1;
                  default:   out_d = out_q;
               endcase
            end
         end
         CH_PWM:  out_d = pol ? below : ~below;
         default: out_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;

   assign pin_out = out_q;

   assert_cmp_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && act == OC_TOGGLE) |=> (pin_out != $past(pin_out)));
   assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_COMPARE && !cmp_hit) |=> $stable(pin_out));
   assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_IDLE) |=> !pin_out);
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

   assign flag = flag_q;
   assign irq  = flag_q & en;

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> !irq);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_val,
   input  logic          cnt_down,
   input  logic          cnt_tick,
   input  logic          tc_strobe,
   input  logic          center_en,
   input  logic [1:0]    mode,
   input  logic [1:0]    edge_sel,
   input  logic          pol,
   input  logic          val_wr,
   input  logic [CW-1:0] val_wdata,
   input  logic          flag_clr,
   input  logic          irq_en,
   input  logic          cap_in,
   output logic          ch_out,
   output logic [CW-1:0] val_rd,
   output logic          flag,
   output logic          irq
);
   localparam logic [CW-1:0] ZERO = '0;

   generate
      if (CW < 2 || CW > 32) begin : g_bad_width
         $error("tmr_chan: CW must lie in 2..32");
      end
   endgenerate

   ch_mode_e      mode_e;
   oc_act_e       act_e;
   logic          edge_hit, cap_evt, match_evt, load_evt;
   logic [CW-1:0] val_q, duty_q;

   assign mode_e = ch_mode_e'(mode);
   assign act_e  = oc_act_e'(edge_sel);

   tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b0)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cap_in), .sel(edge_sel), .hit(edge_hit));

   assign cap_evt  = (mode_e == CH_CAPTURE) && edge_hit;
   assign load_evt = cnt_tick && tc_strobe && (!center_en || !cnt_down);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       val_q <= ZERO;
      else if (cap_evt) val_q <= cnt_val;
      else if (val_wr)  val_q <= val_wdata;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   duty_q <= ZERO;
      else if (mode_e != CH_PWM)    duty_q <= val_q;
      else if (load_evt)            duty_q <= val_q;

   tmr_chan_out #(.CW(CW)) u_out (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .act(act_e), .pol(pol),
      .cnt_val(cnt_val), .cnt_tick(cnt_tick), .cmp_val(val_q), .duty(duty_q),
      .pin_out(ch_out), .hit_evt(match_evt));

   tmr_chan_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(cap_evt | match_evt), .clr(flag_clr),
      .en(irq_en), .flag(flag), .irq(irq));

   assign val_rd = val_q;

   assert_cap_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (val_rd == $past(cnt_val)));
   assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && !cap_evt) |=> (val_rd == $past(val_wdata)));
   assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == CH_PWM && !load_evt) |=> $stable(duty_q));
   assert_idle_noflag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == CH_IDLE && !flag) |=> !flag);
endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] cnt_val = '0, val_wdata = '0;
   logic cnt_down = 0, cnt_tick = 0, tc_strobe = 0, center_en = 0;
   logic [1:0] mode = 2'd3, edge_sel = 2'd0;
   logic pol = 1, val_wr = 0, flag_clr = 0, irq_en = 0, cap_in = 0;
   logic ch_out, flag, irq;
   logic [15:0] val_rd;

   always #2.5 clk = ~clk;

   tmr_chan dut (.*);

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string tag = "R1";

   // bench-side counter
   int bmod = 20, bpresc = 0, dc = 0, c = 0;
   bit brun = 0, bcenter = 0, breload = 0, dn = 0;
   always @(negedge clk) begin
      if (breload) begin c = 0; dn = 0; dc = 0; end
      else if (cnt_tick) begin
         if (!bcenter) c = (c == bmod) ? 0 : c + 1;
         else if (!dn) begin if (c == bmod) begin dn = 1; c = c - 1; end else c = c + 1; end
         else begin if (c == 0) begin dn = 0; c = 1; end else c = c - 1; end
      end
      if (brun && !breload) begin
         if (dc >= bpresc) begin cnt_tick <= 1; dc = 0; end
         else begin cnt_tick <= 0; dc = dc + 1; end
      end else cnt_tick <= 0;
      cnt_val   <= 16'(c);
      cnt_down  <= dn;
      center_en <= bcenter;
      tc_strobe <= bcenter ? ((!dn && c == bmod) || (dn && c == 0)) : (c == bmod);
   end

   // reference model
   int m_val = 0, m_act = 0;
   bit m_out = 0, m_flag = 0, started = 0;
   bit h[3] = '{0, 0, 0};
   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_val = 0; m_act = 0; m_out = 0; m_flag = 0; h = '{0, 0, 0};
      end else begin
         int ov, oa, cv;
         bit fs, ce, rise, fall;
         ov = m_val; oa = m_act; cv = int'(cnt_val); fs = 0; ce = 0;
         rise = h[1] && !h[2]; fall = !h[1] && h[2];
         case (mode)
            2'd0: begin
               if ((rise && edge_sel[0]) || (fall && edge_sel[1])) begin ce = 1; fs = 1; end
               m_out = 0;
            end
            2'd1: if (cnt_tick && cv == ov) begin
               fs = 1;
               if (edge_sel == 1) m_out = !m_out;
               else if (edge_sel == 2) m_out = 0;
               else if (edge_sel == 3) m_out = 1;
            end
            2'd2: begin
               m_out = pol ? (cv < oa) : !(cv < oa);
               if (cnt_tick && cv == oa) fs = 1;
               if (cnt_tick && tc_strobe && (!center_en || !cnt_down)) m_act = ov;
            end
            default: m_out = 0;
         endcase
         if (mode != 2'd2) m_act = ov;
         if (ce) m_val = cv; else if (val_wr) m_val = int'(val_wdata);
         if (fs) m_flag = 1; else if (flag_clr) m_flag = 0;
         h[2] = h[1]; h[1] = h[0]; h[0] = cap_in;
      end
   end

   task automatic chk(string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (started) begin
         chk("ch_out", int'(ch_out), int'(m_out));
         chk("val_rd", int'(val_rd), m_val);
         chk("flag", int'(flag), int'(m_flag));
         chk("irq R10", int'(irq), int'(m_flag && irq_en));
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr(int v);
      @(negedge clk); val_wr = 1; val_wdata = 16'(v);
      @(negedge clk); val_wr = 0;
   endtask
   task automatic clr();
      @(negedge clk); flag_clr = 1;
      @(negedge clk); flag_clr = 0;
   endtask
   task automatic restart(int md, bit ctr, int pr);
      @(negedge clk); brun = 0; breload = 1; bmod = md; bcenter = ctr; bpresc = pr;
      @(negedge clk); breload = 0; brun = 1;
   endtask
   task automatic pulse_pin(int gap);
      @(negedge clk); cap_in = ~cap_in; cyc(gap);
   endtask

   initial begin
      tag = "R1"; cyc(4);
      chk("reset ch_out R1", int'(ch_out), 0);
      chk("reset flag R1", int'(flag), 0);
      @(negedge clk); rst_n = 1;
      tag = "R11"; mode = 2'd3; restart(30, 0, 0);
      wr(7); cyc(40); pulse_pin(6); pulse_pin(6);
      tag = "R2"; mode = 2'd0; edge_sel = 2'd1; irq_en = 1;
      for (int i = 0; i < 6; i++) pulse_pin(5 + i);
      clr();
      tag = "R3"; edge_sel = 2'd2;
      for (int i = 0; i < 4; i++) pulse_pin(9);
      edge_sel = 2'd3; for (int i = 0; i < 4; i++) pulse_pin(3 + i);
      edge_sel = 2'd0; clr(); for (int i = 0; i < 4; i++) pulse_pin(4);
      tag = "R4"; edge_sel = 2'd3; @(negedge clk); cap_in = ~cap_in; cyc(1); wr(1234); cyc(5);
      tag = "R5"; mode = 2'd1; edge_sel = 2'd1; restart(25, 0, 1); wr(10); cyc(150);
      edge_sel = 2'd2; cyc(60); edge_sel = 2'd3; cyc(60); edge_sel = 2'd0; wr(25); cyc(60);
      tag = "R9"; clr(); irq_en = 0; cyc(60); clr(); irq_en = 1; cyc(20);
      tag = "R6"; mode = 2'd2; pol = 1; restart(20, 0, 0); wr(5); cyc(70);
      tag = "R7"; wr(12); cyc(11); wr(3); cyc(60);
      tag = "R6"; pol = 0; cyc(45); wr(0); cyc(45); wr(25); cyc(45);
      restart(10, 0, 2); pol = 1; wr(4); cyc(100);
      tag = "R8"; restart(15, 1, 0); wr(6); cyc(80); wr(11); cyc(17); wr(2); cyc(90);
      restart(12, 1, 1); pol = 0; wr(9); cyc(120);
      tag = "R9"; clr(); cyc(10);
      tag = "R11"; mode = 2'd3; wr(77); cyc(40);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule